// File: doc/BRIEF.md
# Serial Stereo Attenuator Control Register

This block is the digital control section of a two-channel stepped volume attenuator. A host writes a 16-bit frame over a three-wire serial link made of a chip-enable line, a data line and a serial clock. The block samples the three wires with the system clock, shifts the data in, and checks that exactly sixteen bits arrived before chip enable dropped. Each frame carries a coarse code (8 dB steps) and a fine code (1 dB steps) for each channel.

A decoded frame does not reach the outputs straight away. Each channel keeps the new setting in a pending register. The setting moves into that channel's active latch on the next zero-crossing pulse for the channel, so the level changes while the audio is near zero. If no zero crossing arrives within a set number of system clock cycles, the setting is applied anyway.

A separate active-low initialise input returns both channels to mute with the fine step at 7 dB, and drops any pending settings. It acts only while the serial clock line is high. The outputs give each channel's attenuation in dB and a mute flag, and they drive the analog ladder selection.

Top module: `serial_attn_ctrl`

## Requirements
- R1: The frame is shifted in first bit first, with bit 1 going to the most significant position. Bits 1 and 9 are ignored. Channel 0 takes its coarse code from bits 2–5 and its fine code from bits 6–8. Channel 1 takes its coarse code from bits 10–13 and its fine code from bits 14–16. Each field is sent most significant bit first.
- R2: A frame is accepted only when chip enable falls after exactly 16 rising serial-clock edges. Frames of any other length leave all state unchanged.
- R3: Data is sampled only on rising serial-clock edges while chip enable is high. Serial-clock edges while chip enable is low change nothing.
- R4: A coarse code from 1111 down to 0101 gives 0, 8, … 80 dB, i.e. (15 − code) × 8 dB, with the mute flag low. An unmuted attenuation never exceeds 87.
- R5: Coarse codes 0000 to 0100 mute the channel: mute_o bit = 1 and the channel's attenuation field reads 127 (all ones).
- R6: A fine code adds (7 − code) dB to the coarse attenuation, so 111 adds 0 dB and 000 adds 7 dB.
- R7: A channel's pending setting moves to its active latch on a zero-cross pulse on that channel's zc_i bit (bit 0 for channel 0, bit 1 for channel 1). The other channel is not affected. The active setting changes only on a zero-cross pulse, a timeout or a reset.
- R8: If no zero-cross pulse arrives, a pending setting is applied TIMEOUT_CYC cycles after it was captured.
- R9: initn_i low while sclk_i is high sets both channels to coarse mute and fine 000, and discards any pending setting.
- R10: initn_i low while sclk_i is low has no effect.
- R11: After rst_ni, both channels are muted (mute_o = 2'b11, both attenuation fields 127).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low system reset |
| sclk_i | input | 1 | Serial clock, asynchronous to clk_i |
| sdata_i | input | 1 | Serial data |
| scen_i | input | 1 | Serial chip enable, high during a frame |
| initn_i | input | 1 | Active-low initialise, valid only while sclk_i is high |
| zc_i | input | 2 | Per-channel zero-cross pulse, synchronous to clk_i |
| mute_o | output | 2 | Per-channel mute flag |
| atten_o | output | 14 | Attenuation in dB: channel 0 in [6:0], channel 1 in [13:7] |

## Verification
The assertions assume the serial wires change slowly compared with clk_i, so that every serial-clock level lasts longer than the synchroniser delay. They also assume zc_i is a clean pulse aligned to the system clock. The stimulus holds every serial-clock phase and every data and chip-enable setup time for 50 system cycles. It leaves 400 cycles between frames. It drives each zero-cross bit high for exactly one cycle. The initialise input is moved only while the serial clock is held steady, so the gating is seen with one serial-clock level at a time.

// File: rtl/sac_pkg.sv
// Shared constants and types for the serial attenuator control block.
// Assumes a fixed two-field slot per channel: coarse code then fine code.
package sac_pkg;
    localparam int COARSE_W      = 4;
    localparam int FINE_W        = 3;
    localparam int SET_W         = COARSE_W + FINE_W;
    localparam int ATTEN_W       = 7;
    localparam int COARSE_DB     = 8;
    localparam int MUTE_CODE_TOP = 4;
    localparam int COARSE_MAX    = (1 << COARSE_W) - 1;
    localparam int FINE_MAX      = (1 << FINE_W) - 1;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } vol_set_t;

    localparam vol_set_t SET_RESET = '{coarse: '0, fine: '0};
    localparam logic [ATTEN_W-1:0] MUTE_ATTEN = '1;
endpackage

// File: rtl/sac_serial_rx.sv
// Serial frame receiver. Synchronises the three serial wires and the
// initialise input to clk_i, shifts data in on rising serial-clock edges
// while chip enable is high, and flags a frame when chip enable falls
// after exactly FRAME_BITS bits. Assumes every serial level outlasts the
// synchroniser delay.
module sac_serial_rx #(
    parameter int FRAME_BITS  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  sclk_i,
    input  logic                  sdata_i,
    input  logic                  scen_i,
    input  logic                  initn_i,
    output logic                  frame_vld_o,
    output logic [FRAME_BITS-1:0] frame_o,
    output logic                  clear_o
);
    localparam int CNT_W   = $clog2(FRAME_BITS + 2);
    localparam int CNT_SAT = FRAME_BITS + 1;
    localparam logic [3:0] SY_RST = 4'b1000;

    logic [SYNC_STAGES-1:0][3:0] sy_q;
    logic                        sclk_s, data_s, ce_s, initn_s;
    logic                        sclk_d_q, ce_d_q;
    logic                        sclk_rise, ce_rise, ce_fall;
    logic [CNT_W-1:0]            cnt_q;
    logic [FRAME_BITS-1:0]       shreg_q;
    logic                        frame_vld_q;

    // Bring the serial wires and initialise into the clk_i domain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) sy_q <= {SYNC_STAGES{SY_RST}};
        else         sy_q <= {sy_q[SYNC_STAGES-2:0], {initn_i, scen_i, sdata_i, sclk_i}};
    end

    assign sclk_s  = sy_q[SYNC_STAGES-1][0];
    assign data_s  = sy_q[SYNC_STAGES-1][1];
    assign ce_s    = sy_q[SYNC_STAGES-1][2];
    assign initn_s = sy_q[SYNC_STAGES-1][3];

    // Keep last synchronised levels for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sclk_d_q <= 1'b0;
            ce_d_q   <= 1'b0;
        end else begin
            sclk_d_q <= sclk_s;
            ce_d_q   <= ce_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d_q;
    assign ce_rise   = ce_s & ~ce_d_q;
    assign ce_fall   = ~ce_s & ce_d_q;
    assign clear_o   = ~initn_s & sclk_s;

    // Count and shift serial bits while chip enable is high.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (clear_o || ce_rise) begin
            cnt_q   <= '0;
        end else if (ce_s && sclk_rise) begin
            shreg_q <= {shreg_q[FRAME_BITS-2:0], data_s};
            if (cnt_q != CNT_W'(CNT_SAT)) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag a complete frame when chip enable ends an exact-length burst.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) frame_vld_q <= 1'b0;
        else         frame_vld_q <= ce_fall && !clear_o && (cnt_q == CNT_W'(FRAME_BITS));
    end

    assign frame_vld_o = frame_vld_q;
    assign frame_o     = shreg_q;

    // R3
    shift_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ce_s |=> $stable(shreg_q));
    // R2
    frame_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_vld_q |=> !frame_vld_q);
    // R2
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CNT_W'(CNT_SAT));
endmodule

// File: rtl/sac_chan_latch.sv
// Per-channel pending and active volume latches. A captured setting waits
// in the pending register until a zero-cross pulse or a timeout, then
// moves to the active latch. Assumes zc_i is a one-cycle pulse in clk_i.
module sac_chan_latch
    import sac_pkg::*;
#(
    parameter int TIMEOUT_CYC = 20000
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     clear_i,
    input  logic     frame_vld_i,
    input  vol_set_t set_i,
    input  logic     zc_i,
    output vol_set_t act_o
);
    localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

    vol_set_t         act_q, pend_q;
    logic             pend_v_q;
    logic [TMR_W-1:0] tmr_q;
    logic             apply;

    assign apply = pend_v_q && (zc_i || (tmr_q == TMR_LAST));

    // Capture new settings, age them, and transfer on zero cross or timeout.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clear_i) begin
            act_q    <= SET_RESET;
            pend_q   <= SET_RESET;
            pend_v_q <= 1'b0;
            tmr_q    <= '0;
        end else if (frame_vld_i) begin
            pend_q   <= set_i;
            pend_v_q <= 1'b1;
            tmr_q    <= '0;
        end else if (apply) begin
            act_q    <= pend_q;
            pend_v_q <= 1'b0;
            tmr_q    <= '0;
        end else if (pend_v_q) begin
            tmr_q    <= tmr_q + 1'b1;
        end
    end

    assign act_o = act_q;

    // R7
    act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!zc_i && !clear_i && !(pend_v_q && tmr_q == TMR_LAST)) |=> $stable(act_q));
    // R8
    tmr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmr_q <= TMR_LAST);
    // R9
    clear_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (act_q == SET_RESET) && !pend_v_q);
endmodule

// File: rtl/sac_vol_decode.sv
// Turns an active coarse/fine setting into an attenuation magnitude in dB
// and a mute flag. Low coarse codes force mute and an all-ones magnitude.
module sac_vol_decode
    import sac_pkg::*;
(
    input  vol_set_t           set_i,
    output logic               mute_o,
    output logic [ATTEN_W-1:0] atten_o
);
    int sum;

    // Combine coarse and fine steps, or mute for the reserved coarse range.
    always_comb begin
        sum = (COARSE_MAX - int'(set_i.coarse)) * COARSE_DB + (FINE_MAX - int'(set_i.fine));
        if (int'(set_i.coarse) <= MUTE_CODE_TOP) begin
            mute_o  = 1'b1;
            atten_o = MUTE_ATTEN;
        end else begin
            mute_o  = 1'b0;
            atten_o = ATTEN_W'(sum);
        end
    end

    // R5
    mute_field_chk: assert property (@(set_i) mute_o |-> atten_o == MUTE_ATTEN);
    // R4
    range_chk: assert property (@(set_i) !mute_o |-> atten_o <= ATTEN_W'(87));
endmodule

// File: rtl/serial_attn_ctrl.sv
// Top of the serial stereo attenuator control. Receives 16-bit frames,
// splits them into one coarse/fine slot per channel, holds each channel's
// update for its zero-cross pulse, and presents dB and mute per channel.
module serial_attn_ctrl
    import sac_pkg::*;
#(
    parameter int TIMEOUT_CYC = 20000,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        sclk_i,
    input  logic        sdata_i,
    input  logic        scen_i,
    input  logic        initn_i,
    input  logic [1:0]  zc_i,
    output logic [1:0]  mute_o,
    output logic [13:0] atten_o
);
    localparam int N_CH       = 2;
    localparam int FRAME_BITS = 16;
    localparam int SLOT_W     = FRAME_BITS / N_CH;

    logic                  frame_vld;
    logic [FRAME_BITS-1:0] frame;
    logic                  clear;

    sac_serial_rx #(
        .FRAME_BITS (FRAME_BITS),
        .SYNC_STAGES(SYNC_STAGES)
    ) rx_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sclk_i     (sclk_i),
        .sdata_i    (sdata_i),
        .scen_i     (scen_i),
        .initn_i    (initn_i),
        .frame_vld_o(frame_vld),
        .frame_o    (frame),
        .clear_o    (clear)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        localparam int BASE = (N_CH - 1 - ch) * SLOT_W;
        vol_set_t slot_set, act_set;

        assign slot_set = vol_set_t'(frame[BASE +: SET_W]);

        sac_chan_latch #(
            .TIMEOUT_CYC(TIMEOUT_CYC)
        ) latch_i (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .clear_i    (clear),
            .frame_vld_i(frame_vld),
            .set_i      (slot_set),
            .zc_i       (zc_i[ch]),
            .act_o      (act_set)
        );

        sac_vol_decode dec_i (
            .set_i  (act_set),
            .mute_o (mute_o[ch]),
            .atten_o(atten_o[ch*ATTEN_W +: ATTEN_W])
        );
    end
endmodule

// File: tb/serial_attn_ctrl_tb.sv
`timescale 1ns/1ps
module serial_attn_ctrl_tb_top;
    localparam int HALF = 50;
    localparam int GAP  = 400;
    localparam int TO   = 1000;

    typedef struct {
        string       req;
        logic [1:0]  mute;
        logic [13:0] att;
    } exp_t;

    logic clk = 0, rst_n = 0, sclk = 0, sdata = 0, scen = 0, initn = 1;
    logic [1:0]  zc = 0;
    logic [1:0]  mute;
    logic [13:0] att;
    exp_t q[$];
    int n_chk = 0, n_err = 0;
    bit  done = 0;

    always #5 clk = ~clk;

    serial_attn_ctrl #(.TIMEOUT_CYC(TO)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata),
        .scen_i(scen), .initn_i(initn), .zc_i(zc), .mute_o(mute), .atten_o(att));

    // Reference decode of one channel from R4, R5, R6.
    function automatic void model(input logic [3:0] c, input logic [2:0] f,
                                  output logic m, output logic [6:0] a);
        if (c <= 4) begin m = 1; a = 7'h7F; end
        else begin m = 0; a = 7'((15 - int'(c)) * 8 + (7 - int'(f))); end
    endfunction

    // Monitor: pops expectations and compares with the outputs.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (mute !== e.mute || att !== e.att) begin
                n_err++;
                $display("FAIL %s: got mute=%b att=%h, expected mute=%b att=%h",
                         e.req, mute, att, e.mute, e.att);
            end
        end
    end

    task automatic expect_ch(input string req, input logic [3:0] c0, input logic [2:0] f0,
                             input logic [3:0] c1, input logic [2:0] f1);
        exp_t e;
        logic m0, m1;
        logic [6:0] a0, a1;
        model(c0, f0, m0, a0);
        model(c1, f1, m1, a1);
        e.req = req; e.mute = {m1, m0}; e.att = {a1, a0};
        q.push_back(e);
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n);
        repeat (GAP) @(negedge clk);
        scen = 1;
        repeat (HALF) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sdata = bits[i];
            repeat (HALF) @(negedge clk);
            sclk = 1;
            repeat (HALF) @(negedge clk);
            sclk = 0;
        end
        repeat (HALF) @(negedge clk);
        scen = 0;
        repeat (20) @(negedge clk);
    endtask

    task automatic send_frame(input logic n1, input logic [3:0] c0, input logic [2:0] f0,
                              input logic n9, input logic [3:0] c1, input logic [2:0] f1);
        send_bits({16'h0, n1, c0, f0, n9, c1, f1}, 16);
    endtask

    task automatic pulse_zc(input logic [1:0] m);
        @(negedge clk); zc = m;
        @(negedge clk); zc = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_init(input logic sclk_level);
        @(negedge clk); sclk = sclk_level;
        repeat (10) @(negedge clk); initn = 0;
        repeat (10) @(negedge clk); initn = 1;
        repeat (10) @(negedge clk); sclk = 0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
        // R11 reset state
        expect_ch("R11", 0, 0, 0, 0);

        // R1 R7: frame held until each channel's own zero cross
        send_frame(1, 4'hF, 3'h7, 1, 4'hE, 3'h5);
        expect_ch("R7 pending", 0, 0, 0, 0);
        pulse_zc(2'b01);
        expect_ch("R7 ch0 only", 4'hF, 3'h7, 0, 0);
        pulse_zc(2'b10);
        expect_ch("R1", 4'hF, 3'h7, 4'hE, 3'h5);

        // R4 R5 R6: sweep every coarse code, varied fine codes and nop bits
        for (int c = 0; c < 16; c++) begin
            send_frame(1'(c), 4'(c), 3'(c), 1'(~c), 4'(15 - c), 3'(7 - (c % 8)));
            pulse_zc(2'b11);
            expect_ch(c <= 4 ? "R5" : "R4 R6", 4'(c), 3'(c), 4'(15 - c), 3'(7 - (c % 8)));
        end

        // R2: short and long frames are dropped
        send_frame(0, 4'hA, 3'h3, 0, 4'hB, 3'h1);
        pulse_zc(2'b11);
        expect_ch("R2 base", 4'hA, 3'h3, 4'hB, 3'h1);
        send_bits(32'h7FFF, 15);
        pulse_zc(2'b11);
        expect_ch("R2 short", 4'hA, 3'h3, 4'hB, 3'h1);
        send_bits(32'h1FFFF, 17);
        pulse_zc(2'b11);
        expect_ch("R2 long", 4'hA, 3'h3, 4'hB, 3'h1);

        // R3: serial clocks with chip enable low change nothing
        for (int i = 0; i < 16; i++) begin
            sdata = 1'(i);
            repeat (HALF) @(negedge clk); sclk = 1;
            repeat (HALF) @(negedge clk); sclk = 0;
        end
        pulse_zc(2'b11);
        expect_ch("R3", 4'hA, 3'h3, 4'hB, 3'h1);

        // R8: no zero cross, applied after the timeout
        send_frame(0, 4'h9, 3'h6, 0, 4'h5, 3'h0);
        repeat (600) @(negedge clk);
        expect_ch("R8 early", 4'hA, 3'h3, 4'hB, 3'h1);
        repeat (500) @(negedge clk);
        expect_ch("R8 late", 4'h9, 3'h6, 4'h5, 3'h0);

        // R10: initialise with serial clock low is ignored
        do_init(1'b0);
        expect_ch("R10", 4'h9, 3'h6, 4'h5, 3'h0);

        // R9: initialise with serial clock high resets and drops pending
        send_frame(0, 4'hC, 3'h2, 0, 4'hD, 3'h4);
        do_init(1'b1);
        expect_ch("R9 reset", 0, 0, 0, 0);
        pulse_zc(2'b11);
        expect_ch("R9 pending dropped", 0, 0, 0, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule